// File: doc/BRIEF.md
# Cycle Counter with Tap Postscaler

A free-running cycle counter that also makes a slow periodic event and a trace synchronization tick. When counting is on, the counter adds one on every clock and wraps silently. One of two low counter bits is watched. Each time counting flips that bit, a 4-bit down-counting postscaler takes one step. When the postscaler is already at zero on such a step, it reloads from a preset value and a one-cycle cycle event pulse is raised, as long as that pulse is enabled and profiling sampling is off.

A separate field picks one of three high counter bits, or none. Each flip of the chosen bit, caused by counting, gives a one-cycle synchronization tick for a trace stream. Software reaches the block through a simple write port with a select between the control word and the counter. Both registers are always visible on read outputs.

Control word layout, as bit positions: [0] count enable, [4:1] postscaler preset, [8:5] postscaler value, [9] tap select, [11:10] sync select, [12] sampling-mode inhibit, [22] event enable. All other bits read as zero.

Top module: `cyc_tap_counter`

## Requirements
- R1: After reset (rst_n low) the control word, the counter, cyc_evt and sync_tick are all zero.
- R2: With control bit 0 set, the counter grows by one on every clock. With it clear, the counter holds its value.
- R3: A write with reg_sel=1 loads reg_wdata into the counter on that clock. This write takes priority over the increment on the same clock.
- R4: The counter wraps from 0xFFFFFFFF to 0 and raises no flag.
- R5: Control bit 9 picks the tapped bit: 0 selects counter bit 6 and 1 selects counter bit 10. A tap event is a change of the tapped bit caused by an increment. A change made by a counter write is not a tap event.
- R6: On a tap event the postscaler field [8:5] goes down by one if it is nonzero. If it is zero, it reloads from the preset [4:1] and a cycle event is due.
- R7: cyc_evt is a one-cycle pulse. It is high in the cycle after the clock edge of the due tap event, and only when control bit 22 is 1 and bit 12 is 0. The postscaler keeps running while the pulse is gated off.
- R8: Sync select [11:10] is decoded as 00 = off, 01 = counter bit 24, 10 = bit 26, 11 = bit 28. sync_tick is high for one cycle after each increment that changes the chosen bit.
- R9: A write with reg_sel=0 loads the control word. Bits outside the fields listed above read back as 0. On the same clock, this write takes priority over a postscaler step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = counter |
| reg_wdata | input | 32 | Write data |
| ctrl_rd | output | 32 | Current control word |
| count_rd | output | 32 | Current counter value |
| cyc_evt | output | 1 | Postscaled cycle event pulse |
| sync_tick | output | 1 | Trace synchronization pulse |

## Verification
Register writes take effect at the edge that samples the strobe, so the bench reads both registers right after that edge. The increment, the tap decision, the postscaler step and both pulses all come from one edge. The two pulses are therefore high exactly one clock after the increment that flips the watched bit, which is two clocks after a counter write that sets the value to two below the flip. The bench drives and samples on falling edges and checks the pulse in that cycle and again one cycle later. This shows both that the pulse arrives on time and that it lasts a single cycle.

// File: rtl/cyc_tap_counter.sv
module cyc_tap_counter #(
  parameter int CW        = 32,
  parameter int LO_TAP    = 6,
  parameter int HI_TAP    = 10,
  parameter int SYNC_BASE = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [CW-1:0] reg_wdata,
  output logic [31:0]   ctrl_rd,
  output logic [CW-1:0] count_rd,
  output logic          cyc_evt,
  output logic          sync_tick
);
  localparam int PW = 4;

  logic          run_en, tap_sel, samp_inh, evt_en;
  logic [1:0]    sync_sel;
  logic [PW-1:0] preset, post;
  logic [CW-1:0] count;
  logic [CW-1:0] count_inc;
  logic          wr_ctrl, wr_cnt, inc, tap_ev, sync_ev;
  logic          sync_old, sync_new;

  assign wr_ctrl   = reg_wr & ~reg_sel;
  assign wr_cnt    = reg_wr &  reg_sel;
  assign inc       = run_en & ~wr_cnt;
  assign count_inc = count + 1'b1;

  assign tap_ev = inc & (tap_sel ? (count[HI_TAP] ^ count_inc[HI_TAP])
                                 : (count[LO_TAP] ^ count_inc[LO_TAP]));

  always_comb begin
    case (sync_sel)
      2'd1:    begin sync_old = count[SYNC_BASE];   sync_new = count_inc[SYNC_BASE];   end
      2'd2:    begin sync_old = count[SYNC_BASE+2]; sync_new = count_inc[SYNC_BASE+2]; end
      2'd3:    begin sync_old = count[SYNC_BASE+4]; sync_new = count_inc[SYNC_BASE+4]; end
      default: begin sync_old = 1'b0;               sync_new = 1'b0;                   end
    endcase
  end
  assign sync_ev = inc & (sync_old ^ sync_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_cnt) begin
      count <= reg_wdata;
    end else if (run_en) begin
      count <= count_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      preset   <= '0;
      post     <= '0;
      tap_sel  <= 1'b0;
      sync_sel <= 2'd0;
      samp_inh <= 1'b0;
      evt_en   <= 1'b0;
    end else if (wr_ctrl) begin
      run_en   <= reg_wdata[0];
      preset   <= reg_wdata[4:1];
      post     <= reg_wdata[8:5];
      tap_sel  <= reg_wdata[9];
      sync_sel <= reg_wdata[11:10];
      samp_inh <= reg_wdata[12];
      evt_en   <= reg_wdata[22];
    end else if (tap_ev) begin
      post <= (post == '0) ? preset : post - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_evt   <= 1'b0;
      sync_tick <= 1'b0;
    end else begin
      cyc_evt   <= tap_ev & (post == '0) & evt_en & ~samp_inh;
      sync_tick <= sync_ev;
    end
  end

  assign count_rd = count;
  assign ctrl_rd  = {9'd0, evt_en, 9'd0, samp_inh, sync_sel, tap_sel, post, preset, run_en};

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_cnt) |=> $stable(count_rd));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !wr_cnt) |=> count_rd == CW'($past(count_rd) + 1'b1));
  assert_wr_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count_rd == $past(reg_wdata));
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_ev && !wr_ctrl && post == '0) |=> ctrl_rd[8:5] == $past(ctrl_rd[4:1]));
  assert_evt_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_evt |-> $past(ctrl_rd[22] && !ctrl_rd[12]));
  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_evt |=> !cyc_evt);
  assert_sync_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_tick |-> $past(ctrl_rd[11:10] != 2'd0 && ctrl_rd[0]));
endmodule

// File: tb/cyc_tap_counter_bench.sv
module cyc_tap_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rd, count_rd;
  logic        cyc_evt, sync_tick;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cyc_tap_counter u_cyc_tap_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .count_rd(count_rd),
    .cyc_evt(cyc_evt), .sync_tick(sync_tick)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_rd, 0);
    chk("R1 count", count_rd, 0);
    chk("R1 evt", {31'd0, cyc_evt}, 0);
    chk("R1 sync", {31'd0, sync_tick}, 0);
  endtask

  task automatic t_enable;
    wr(1'b1, 32'd5);
    tick(3);
    chk("R2 hold", count_rd, 5);
    wr(1'b0, 32'h1);
    chk("R2 first", count_rd, 5);
    tick(4);
    chk("R2 count", count_rd, 9);
  endtask

  task automatic t_wr_prio;
    wr(1'b1, 32'h1234);
    chk("R3 write wins", count_rd, 32'h1234);
    tick(1);
    chk("R3 then count", count_rd, 32'h1235);
  endtask

  task automatic t_wrap;
    wr(1'b1, 32'hFFFF_FFFE);
    tick(1);
    chk("R4 max", count_rd, 32'hFFFF_FFFF);
    tick(1);
    chk("R4 wrap", count_rd, 0);
    tick(1);
    chk("R4 after", count_rd, 1);
  endtask

  task automatic t_tap_low;
    wr(1'b0, 32'h0040_0001);
    wr(1'b1, 32'd62);
    tick(1);
    chk("R5 pre", {31'd0, cyc_evt}, 0);
    tick(1);
    chk("R5 bit6 evt", {31'd0, cyc_evt}, 1);
    tick(1);
    chk("R7 one cycle", {31'd0, cyc_evt}, 0);
    wr(1'b1, 32'h0);
    wr(1'b1, 32'h40);
    chk("R5 write no evt a", {31'd0, cyc_evt}, 0);
    tick(1);
    chk("R5 write no evt b", {31'd0, cyc_evt}, 0);
  endtask

  task automatic t_tap_high;
    wr(1'b0, 32'h0040_0201);
    wr(1'b1, 32'd62);
    tick(2);
    chk("R5 bit6 ignored", {31'd0, cyc_evt}, 0);
    wr(1'b1, 32'h3FE);
    tick(1);
    chk("R5 bit10 pre", {31'd0, cyc_evt}, 0);
    tick(1);
    chk("R5 bit10 evt", {31'd0, cyc_evt}, 1);
    tick(1);
    chk("R5 bit10 end", {31'd0, cyc_evt}, 0);
  endtask

  task automatic t_postscale;
    wr(1'b0, 32'h0040_0045);
    wr(1'b1, 32'd62); tick(2);
    chk("R6 step1 evt", {31'd0, cyc_evt}, 0);
    chk("R6 step1 post", {28'd0, ctrl_rd[8:5]}, 1);
    wr(1'b1, 32'd62); tick(2);
    chk("R6 step2 evt", {31'd0, cyc_evt}, 0);
    chk("R6 step2 post", {28'd0, ctrl_rd[8:5]}, 0);
    wr(1'b1, 32'd62); tick(2);
    chk("R6 step3 evt", {31'd0, cyc_evt}, 1);
    chk("R6 reload", {28'd0, ctrl_rd[8:5]}, 2);
  endtask

  task automatic t_gate;
    wr(1'b0, 32'h0040_1023);
    wr(1'b1, 32'd62); tick(2);
    chk("R7 inh post", {28'd0, ctrl_rd[8:5]}, 0);
    wr(1'b1, 32'd62); tick(2);
    chk("R7 inh no evt", {31'd0, cyc_evt}, 0);
    chk("R7 inh reload", {28'd0, ctrl_rd[8:5]}, 1);
    wr(1'b0, 32'h0000_0001);
    wr(1'b1, 32'd62); tick(2);
    chk("R7 disabled no evt", {31'd0, cyc_evt}, 0);
    wr(1'b0, 32'h0040_0001);
    wr(1'b1, 32'd62); tick(2);
    chk("R7 reenabled evt", {31'd0, cyc_evt}, 1);
  endtask

  task automatic t_sync;
    wr(1'b0, 32'h0000_0001);
    wr(1'b1, 32'h00FF_FFFE); tick(2);
    chk("R8 off", {31'd0, sync_tick}, 0);
    wr(1'b0, 32'h0000_0401);
    wr(1'b1, 32'h00FF_FFFE); tick(1);
    chk("R8 b24 pre", {31'd0, sync_tick}, 0);
    tick(1);
    chk("R8 b24 tick", {31'd0, sync_tick}, 1);
    tick(1);
    chk("R8 b24 end", {31'd0, sync_tick}, 0);
    wr(1'b0, 32'h0000_0801);
    wr(1'b1, 32'h00FF_FFFE); tick(2);
    chk("R8 b26 ignores b24", {31'd0, sync_tick}, 0);
    wr(1'b1, 32'h03FF_FFFE); tick(2);
    chk("R8 b26 tick", {31'd0, sync_tick}, 1);
    wr(1'b0, 32'h0000_0C01);
    wr(1'b1, 32'h0FFF_FFFE); tick(2);
    chk("R8 b28 tick", {31'd0, sync_tick}, 1);
  endtask

  task automatic t_ctrl;
    wr(1'b0, 32'hFFFF_FFFF);
    chk("R9 readback", ctrl_rd, 32'h0040_1FFF);
    wr(1'b0, 32'h0040_0001);
    wr(1'b1, 32'd63);
    wr(1'b0, 32'h0040_00A1);
    chk("R9 write over step", ctrl_rd, 32'h0040_00A1);
    wr(1'b0, 32'h0);
  endtask

  initial begin
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(1);
    t_enable;
    t_wr_prio;
    t_wrap;
    t_tap_low;
    t_tap_high;
    t_postscale;
    t_gate;
    t_sync;
    t_ctrl;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule